// File: doc/BRIEF.md
# Port-Write Capture Unit

This block takes maintenance port-write messages arriving from a serial interconnect and holds one of them in a single-slot queue for software. Each message is a fixed frame of sixteen 32-bit words delivered on a valid/data stream, with an end marker on the final word. A correctly framed message that arrives while the slot is empty is stored in an internal word array. That array stands in for the copy to system memory. The unit then reports the capture through a status register and an interrupt.

The slot stays occupied until software issues an explicit clear-queue command. Messages that complete while the slot is occupied are dropped and flagged. Frames with the wrong length raise a transaction-error flag. That flag can be cleared only while the unit is disabled.

Software uses a small register window with three registers: a mode register, a status register and a queue base address register. It reads the captured words through a word-index port.

Top module: `pwc_unit`

## Requirements
- R1: Mode register (address 0) keeps only bit 0 (enable), bit 5 (error interrupt enable), bit 8 (capture interrupt enable) and bit 20 (snoop enable). Bit 1 (clear-queue) and all other bits always read as zero. After reset the register reads zero.
- R2: After reset the status register (address 1) reads zero and `irq` is low.
- R3: A frame that meets both conditions is captured. The unit must be enabled with the slot empty, and the frame must have exactly 16 words with the end marker on the 16th. On capture, status bit 20 (slot full) and bit 4 (capture interrupt) are set, and word k of the frame reads back on `cap_word` when `cap_idx` = k.
- R4: A well-formed frame that completes while the slot is full is dropped. The stored words are left unchanged, and status bit 3 (dropped message) is set.
- R5: Writing the mode register with bit 1 set empties the slot and clears status bit 20. The next well-formed frame is then captured.
- R6: A frame whose end marker arrives on any word other than the 16th sets status bit 7 (transaction error). Frames that are too short and frames that are too long both count. Such a frame is not captured.
- R7: Writing a one to status bit 7 clears it only if the enable bit was zero before the write. While the unit is enabled, that write has no effect.
- R8: Status bits 4 and 3 are cleared by writing a one to them, and a zero written to them has no effect. Writing 0x98 while the unit is disabled clears bits 7, 4 and 3 together.
- R9: `irq` is high exactly when (status bit 4 and mode bit 8) or (status bit 7 and mode bit 5).
- R10: While the enable bit is zero, stream words are ignored and no status bit changes because of them.
- R11: The queue base register (address 2) accepts a write only when the enable bit was zero before the write. A write while enabled is ignored.
- R12: Status bit 2 (busy) is high while a frame is partly received and low once its end marker has been taken.
- R13: Every event uses the register state from before the cycle, and a hardware set wins over a software clear. A frame that completes in the cycle of a clear-queue write is dropped: bit 3 is set and bit 20 ends clear. A drop in the same cycle as a write-one-to-clear of bit 3 leaves bit 3 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 status, 2 queue base, 3 reads zero |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| pw_valid | input | 1 | Stream word valid |
| pw_data | input | 32 | Stream word |
| pw_last | input | 1 | End marker on the current word |
| cap_idx | input | 4 | Index of the captured word to read |
| cap_word | output | 32 | Captured word selected by `cap_idx` |

## Verification
Two pairs of functions can land in the same clock cycle:
- Completion of a frame and a software write to the mode or status register.
- A dropped-message set and a write-one-to-clear of the same flag.

The bench provokes both pairs by raising the register write strobe on the exact cycle that carries the final word of a frame. It then judges the result against R13: the clear-queue write does not rescue the frame, and the set of the dropped flag survives the clear. A cycle-by-cycle reference model also tracks every register read, the interrupt and the captured words throughout the run.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   localparam int REG_W     = 32;
   // mode register fields
   localparam int MODE_EN   = 0;
   localparam int MODE_CQ   = 1;
   localparam int MODE_EIE  = 5;
   localparam int MODE_QFIE = 8;
   localparam int MODE_SEN  = 20;
   // status register fields
   localparam int ST_QF     = 20;
   localparam int ST_TE     = 7;
   localparam int ST_QFI    = 4;
   localparam int ST_PWD    = 3;
   localparam int ST_BUSY   = 2;

   typedef enum logic [1:0] {
      RA_MODE = 2'd0,
      RA_STAT = 2'd1,
      RA_BASE = 2'd2,
      RA_NONE = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic qf;
      logic te;
      logic qfi;
      logic pwd;
   } stat_t;
endpackage

// File: rtl/pwc_rx_frame.sv
module pwc_rx_frame #(
   parameter int MSG_WORDS = 16,
   localparam int CNT_W = $clog2(MSG_WORDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             in_valid,
   input  logic             in_last,
   output logic [CNT_W-1:0] word_idx,
   output logic             word_take,
   output logic             frame_ok,
   output logic             frame_bad,
   output logic             busy
);
   logic [CNT_W-1:0] cnt_q;
   logic             take_last;

   assign take_last = en && in_valid && in_last;
   assign word_take = en && in_valid && (cnt_q != CNT_W'(MSG_WORDS));
   assign word_idx  = cnt_q;
   assign frame_ok  = take_last && (cnt_q == CNT_W'(MSG_WORDS - 1));
   assign frame_bad = take_last && (cnt_q != CNT_W'(MSG_WORDS - 1));
   assign busy      = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
      end else if (in_valid) begin
         if (in_last)
            cnt_q <= '0;
         else if (cnt_q != CNT_W'(MSG_WORDS))
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwc_msg_store.sv
module pwc_msg_store #(
   parameter int WORD_W    = 32,
   parameter int MSG_WORDS = 16,
   localparam int CNT_W = $clog2(MSG_WORDS + 1),
   localparam int IDX_W = $clog2(MSG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CNT_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] words [MSG_WORDS];

   for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= '0;
         else if (we && (wr_idx == CNT_W'(g)))
            words[g] <= wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < MSG_WORDS; i++)
         if (rd_idx == IDX_W'(i))
            rd_word = words[i];
   end
endmodule

// File: rtl/pwc_regs.sv
module pwc_regs
   import pwc_pkg::*;
#(
   parameter int BASE_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   input  logic             frame_ok,
   input  logic             frame_bad,
   input  logic             busy,
   output logic             en,
   output stat_t            st,
   output logic             cq_pulse,
   output logic [REG_W-1:0] rdata,
   output logic             irq
);
   logic              en_q, eie_q, qfie_q, sen_q;
   logic [BASE_W-1:0] base_q;
   stat_t             st_q, st_d;
   logic              mode_wr, stat_wr, base_wr;
   logic              capture, discard;
   logic              irq_c;
   logic [REG_W-1:0]  mode_rd, stat_rd;

   assign mode_wr  = wr_en && (addr == RA_MODE);
   assign stat_wr  = wr_en && (addr == RA_STAT);
   assign base_wr  = wr_en && (addr == RA_BASE) && !en_q;
   assign cq_pulse = mode_wr && wdata[MODE_CQ];
   assign capture  = frame_ok && !st_q.qf;
   assign discard  = frame_ok && st_q.qf;

   // hardware sets take priority over software clears
   always_comb begin
      st_d.qf  = capture || (st_q.qf && !cq_pulse);
      st_d.qfi = capture || (st_q.qfi && !(stat_wr && wdata[ST_QFI]));
      st_d.pwd = discard || (st_q.pwd && !(stat_wr && wdata[ST_PWD]));
      st_d.te  = frame_bad || (st_q.te && !(stat_wr && wdata[ST_TE] && !en_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         eie_q  <= 1'b0;
         qfie_q <= 1'b0;
         sen_q  <= 1'b0;
         base_q <= '0;
         st_q   <= '0;
      end else begin
         st_q <= st_d;
         if (mode_wr) begin
            en_q   <= wdata[MODE_EN];
            eie_q  <= wdata[MODE_EIE];
            qfie_q <= wdata[MODE_QFIE];
            sen_q  <= wdata[MODE_SEN];
         end
         if (base_wr)
            base_q <= wdata[BASE_W-1:0];
      end
   end

   always_comb begin
      mode_rd            = '0;
      mode_rd[MODE_EN]   = en_q;
      mode_rd[MODE_EIE]  = eie_q;
      mode_rd[MODE_QFIE] = qfie_q;
      mode_rd[MODE_SEN]  = sen_q;
      stat_rd            = '0;
      stat_rd[ST_QF]     = st_q.qf;
      stat_rd[ST_TE]     = st_q.te;
      stat_rd[ST_QFI]    = st_q.qfi;
      stat_rd[ST_PWD]    = st_q.pwd;
      stat_rd[ST_BUSY]   = busy;
      case (reg_addr_e'(addr))
         RA_MODE: rdata = mode_rd;
         RA_STAT: rdata = stat_rd;
         RA_BASE: rdata = REG_W'(base_q);
         default: rdata = '0;
      endcase
   end

   assign irq_c = (st_q.qfi && qfie_q) || (st_q.te && eie_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   assign en = en_q;
   assign st = st_q;
endmodule

// File: rtl/pwc_unit.sv
module pwc_unit
   import pwc_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MSG_WORDS = 16,
   parameter int BASE_W    = 32,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic [1:0]                   reg_addr,
   input  logic [31:0]                  reg_wdata,
   output logic [31:0]                  reg_rdata,
   output logic                         irq,
   input  logic                         pw_valid,
   input  logic [WORD_W-1:0]            pw_data,
   input  logic                         pw_last,
   input  logic [$clog2(MSG_WORDS)-1:0] cap_idx,
   output logic [WORD_W-1:0]            cap_word
);
   localparam int CNT_W = $clog2(MSG_WORDS + 1);

   if (MSG_WORDS < 2) begin : g_bad_words
      $error("pwc_unit: MSG_WORDS must be at least 2");
   end
   if (BASE_W < 1 || BASE_W > REG_W) begin : g_bad_base
      $error("pwc_unit: BASE_W must be 1..32");
   end

   logic             en_w, busy_w, cq_w;
   logic             ok_w, bad_w, take_w;
   logic [CNT_W-1:0] idx_w;
   stat_t            st_w;
   logic             qf_w, qfi_w, te_w, pwd_w;

   pwc_rx_frame #(.MSG_WORDS(MSG_WORDS)) i_rx (
      .clk(clk), .rst_n(rst_n), .en(en_w),
      .in_valid(pw_valid), .in_last(pw_last),
      .word_idx(idx_w), .word_take(take_w),
      .frame_ok(ok_w), .frame_bad(bad_w), .busy(busy_w)
   );

   pwc_msg_store #(.WORD_W(WORD_W), .MSG_WORDS(MSG_WORDS)) i_store (
      .clk(clk), .rst_n(rst_n),
      .we(take_w && !st_w.qf), .wr_idx(idx_w), .wdata(pw_data),
      .rd_idx(cap_idx), .rd_word(cap_word)
   );

   pwc_regs #(.BASE_W(BASE_W), .IRQ_REG(IRQ_REG)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .frame_ok(ok_w), .frame_bad(bad_w), .busy(busy_w),
      .en(en_w), .st(st_w), .cq_pulse(cq_w),
      .rdata(reg_rdata), .irq(irq)
   );

   assign qf_w  = st_w.qf;
   assign qfi_w = st_w.qfi;
   assign te_w  = st_w.te;
   assign pwd_w = st_w.pwd;
endmodule

// File: rtl/pwc_unit_chk.sv
module pwc_unit_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic qf,
   input logic qfi,
   input logic te,
   input logic pwd,
   input logic frame_ok,
   input logic frame_bad,
   input logic cq_pulse,
   input logic busy
);
   a_r3_capture_fills: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok && !qf |=> qf && qfi);

   a_r4_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok && qf |=> pwd);

   a_r5_full_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
      qf && !cq_pulse |=> qf);

   a_r6_bad_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bad |=> te);

   a_r7_error_kept_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      te && en |=> te);

   a_r10_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !qf |=> !qf);

   a_r12_off_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
endmodule

bind pwc_unit pwc_unit_chk i_chk (
   .clk(clk), .rst_n(rst_n), .en(en_w),
   .qf(qf_w), .qfi(qfi_w), .te(te_w), .pwd(pwd_w),
   .frame_ok(ok_w), .frame_bad(bad_w), .cq_pulse(cq_w), .busy(busy_w)
);

// File: tb/test_pwc_unit.sv
module test_pwc_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        pw_valid = 1'b0;
   logic [31:0] pw_data = '0;
   logic        pw_last = 1'b0;
   logic [3:0]  cap_idx = '0;
   logic [31:0] cap_word;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwc_unit i_pwc_unit (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq),
      .pw_valid(pw_valid), .pw_data(pw_data), .pw_last(pw_last),
      .cap_idx(cap_idx), .cap_word(cap_word)
   );

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_mode, m_base;
   bit        m_qf, m_te, m_qfi, m_pwd;
   int        m_cnt;
   bit [31:0] m_mem [16];
   bit        e_old, f_old, ok, bad, cq, sw;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_base = 0; m_qf = 0; m_te = 0; m_qfi = 0; m_pwd = 0; m_cnt = 0;
         for (int i = 0; i < 16; i++) m_mem[i] = 0;
      end else begin
         e_old = m_mode[0]; f_old = m_qf; ok = 0; bad = 0;
         if (!e_old) m_cnt = 0;
         else if (pw_valid) begin
            if (!f_old && m_cnt < 16) m_mem[m_cnt] = pw_data;
            if (pw_last) begin
               ok = (m_cnt == 15); bad = !ok; m_cnt = 0;
            end else if (m_cnt < 16) m_cnt++;
         end
         cq = reg_wr && reg_addr == 2'd0 && reg_wdata[1];
         sw = reg_wr && reg_addr == 2'd1;
         if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata & 32'h0010_0121;
         if (reg_wr && reg_addr == 2'd2 && !e_old) m_base = reg_wdata;
         if (ok && !f_old) begin m_qf = 1; m_qfi = 1; end
         else begin
            if (cq) m_qf = 0;
            if (sw && reg_wdata[4]) m_qfi = 0;
         end
         if (ok && f_old) m_pwd = 1;
         else if (sw && reg_wdata[3]) m_pwd = 0;
         if (bad) m_te = 1;
         else if (sw && reg_wdata[7] && !e_old) m_te = 0;
      end
   end

   function automatic bit [31:0] m_read(input bit [1:0] a);
      case (a)
         2'd0: return m_mode;
         2'd1: return (32'(m_qf) << 20) | (32'(m_te) << 7) | (32'(m_qfi) << 4) |
                      (32'(m_pwd) << 3) | (32'(m_cnt != 0) << 2);
         2'd2: return m_base;
         default: return 0;
      endcase
   endfunction

   // ---------------- check helpers ----------------
   task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic string addr_tag(input bit [1:0] a);
      case (a)
         2'd0: return "R1 mode read";
         2'd1: return "R3 status read";
         2'd2: return "R11 base read";
         default: return "R1 unused read";
      endcase
   endfunction

   // one clock: model and design update at posedge, compare at negedge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) begin
         chk(addr_tag(reg_addr), reg_rdata, m_read(reg_addr));
         chk("R9 irq", 32'(irq), 32'((m_qfi && m_mode[8]) || (m_te && m_mode[5])));
         chk("R3 captured word", cap_word, m_mem[cap_idx]);
      end
      cap_idx = cap_idx + 1'b1;
   endtask

   task automatic idle();
      reg_wr = 0; pw_valid = 0; pw_last = 0;
      cyc();
   endtask

   task automatic expect_reg(input bit [1:0] a, input bit [31:0] exp, input string tag);
      reg_wr = 0; pw_valid = 0; pw_last = 0; reg_addr = a;
      cyc();
      chk(tag, reg_rdata, exp);
   endtask

   task automatic expect_cap(input int k, input bit [31:0] exp, input string tag);
      cap_idx = 4'(k);
      #1;
      chk(tag, cap_word, exp);
   endtask

   task automatic wr(input bit [1:0] a, input bit [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; pw_valid = 0; pw_last = 0;
      cyc();
      reg_wr = 0;
   endtask

   // words first..n-1 of a frame; optional register write on the final word
   task automatic words(input int first, input int n, input bit [31:0] seed,
                        input bit with_last, input bit cw,
                        input bit [1:0] ca, input bit [31:0] cd);
      for (int i = first; i < n; i++) begin
         pw_valid = 1; pw_data = seed + 32'(i);
         pw_last = with_last && (i == n - 1);
         if (pw_last && cw) begin
            reg_wr = 1; reg_addr = ca; reg_wdata = cd;
         end
         cyc();
         reg_wr = 0;
      end
      pw_valid = 0; pw_last = 0;
   endtask

   task automatic frame(input int n, input bit [31:0] seed);
      words(0, n, seed, 1, 0, 2'd0, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      expect_reg(2'd1, 32'h0, "R2 status after reset");
      chk("R2 irq after reset", 32'(irq), 0);
      expect_reg(2'd0, 32'h0, "R1 mode after reset");

      wr(2'd0, 32'hFFFF_FFFF);
      expect_reg(2'd0, 32'h0010_0121, "R1 mode keeps defined bits, clear-queue reads zero");
      wr(2'd2, 32'h0000_1234);
      expect_reg(2'd2, 32'h0, "R11 base write ignored while enabled");

      // first capture, with a gap to observe busy
      words(0, 3, 32'h100, 1'b0, 0, 2'd0, 0);
      expect_reg(2'd1, 32'h0000_0004, "R12 busy mid-frame");
      words(3, 16, 32'h100, 1'b1, 0, 2'd0, 0);
      expect_reg(2'd1, 32'h0010_0010, "R3 capture sets full and interrupt");
      chk("R9 irq on capture", 32'(irq), 1);
      expect_cap(5, 32'h105, "R3 word 5 captured");
      expect_cap(15, 32'h10F, "R3 word 15 captured");

      frame(16, 32'h200);
      expect_reg(2'd1, 32'h0010_0018, "R4 drop while full flagged");
      expect_cap(5, 32'h105, "R4 stored words unchanged");

      wr(2'd1, 32'h0000_0010);
      expect_reg(2'd1, 32'h0010_0008, "R8 capture interrupt cleared by W1C");
      chk("R9 irq low after clear", 32'(irq), 0);

      wr(2'd0, 32'h0010_0123);
      expect_reg(2'd1, 32'h0000_0008, "R5 clear-queue empties slot");
      expect_reg(2'd0, 32'h0010_0121, "R1 clear-queue bit self-clears");

      frame(8, 32'h300);
      expect_reg(2'd1, 32'h0000_0088, "R6 short frame sets error");
      chk("R9 irq on error", 32'(irq), 1);
      wr(2'd1, 32'h0000_0080);
      expect_reg(2'd1, 32'h0000_0088, "R7 error W1C ignored while enabled");

      frame(18, 32'h400);
      expect_reg(2'd1, 32'h0000_0088, "R6 long frame not captured");

      wr(2'd0, 32'h0000_0120);
      frame(16, 32'h900);
      expect_reg(2'd1, 32'h0000_0088, "R10 words ignored when disabled");
      wr(2'd2, 32'hABCD_0000);
      expect_reg(2'd2, 32'hABCD_0000, "R11 base accepted while disabled");
      wr(2'd1, 32'h0000_0098);
      expect_reg(2'd1, 32'h0, "R8 0x98 clears all when disabled (R7)");
      chk("R9 irq low", 32'(irq), 0);

      // collision: completion with clear-queue
      wr(2'd0, 32'h0010_0121);
      frame(16, 32'h500);
      wr(2'd1, 32'h0000_0010);
      expect_reg(2'd1, 32'h0010_0000, "R3 capture after re-enable");
      words(0, 16, 32'h600, 1'b1, 1'b1, 2'd0, 32'h0010_0123);
      expect_reg(2'd1, 32'h0000_0008, "R13 completion with clear-queue is dropped");
      expect_cap(5, 32'h505, "R13 stored words kept");

      // collision: drop with W1C of drop flag
      frame(16, 32'h700);
      wr(2'd1, 32'h0000_0008);
      expect_reg(2'd1, 32'h0010_0010, "R5 next frame captured after clear");
      expect_cap(0, 32'h700, "R5 new word 0");
      words(0, 16, 32'h800, 1'b1, 1'b1, 2'd1, 32'h0000_0008);
      expect_reg(2'd1, 32'h0010_0018, "R13 drop set beats W1C");

      repeat (4) idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule